// File: doc/BRIEF.md
# Signed-Digit Constant Multiplier

This block multiplies a two's complement fixed-point sample by a constant fixed at elaboration time, using no hardware multiplier. The constant is given as a vector of signed digits, each -1, 0 or +1, carried in two parameter masks. Bit k of `POS_MASK` sets digit k to +1, and bit k of `NEG_MASK` sets it to -1. Each non-zero digit costs exactly one shifted copy of the input. That copy is then added or subtracted.

The partial products are summed in an accumulator that is `GUARD` bits wider than the sample, at the low end. The sum is cut back to the sample format only once, after every term has been added. The result wraps on overflow and is never saturated. A parameter selects whether the output is combinational or registered.

Masks that set the same bit, or that place non-zero digits in adjacent positions, are rejected at elaboration.

Top module: `csd_const_mult`

## Requirements
- R1: `y_o` uses the same format as `x_i`: `DW`-bit two's complement with `FW` fractional bits.
- R2: The constant is the sum over k of (`POS_MASK[k]` - `NEG_MASK[k]`) times 2^(k-`CF`), where `CF` is the number of fractional digits.
- R3: For every non-zero digit k, the input is extended by `GUARD` zero bits below its LSB and shifted. The shift is left by k-`CF` when k >= `CF`, and arithmetic right by `CF`-k otherwise. The shifted copy is added for +1 and subtracted for -1, in a `DW`+`GUARD`-bit accumulator.
- R4: The output is floor(sum / 2^`GUARD`), taken only after all terms are summed. The individual terms are never truncated to the output width.
- R5: Overflow wraps: `y_o` equals the accumulated result modulo 2^`DW`, with no saturation.
- R6: With both masks all zero, `y_o` is zero for every input.
- R7: A zero input gives a zero output for any constant.
- R8: With `OUT_REG`=1, `y_o` is 0 while `rst_ni` is low and follows the input one clock edge later. With `OUT_REG`=0, `y_o` follows `x_i` with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | DW | Input sample, two's complement, FW fractional bits |
| y_o | output | DW | Product sample, same format as x_i |

## Verification
The bench builds the block at `DW`=8, `FW`=4, `CD`=8 and `CF`=4, keeping three guard bits. At this size all 256 input codes can be swept for each constant. Five instances cover the following cases:
- a mixed constant with a fractional part, both registered and combinational;
- a negative constant larger than one, whose products wrap;
- a pure power-of-two constant that wraps, compared against the plain integer product;
- the all-zero constant.

Expected values come from integer arithmetic in the bench on 64-bit values, with the modulo taken only at the end.

// File: rtl/csd_mult_pkg.sv
package csd_mult_pkg;
  typedef enum logic [1:0] {DIG_ZERO, DIG_POS, DIG_NEG} digit_e;

  function automatic digit_e digit_at(input logic pos, input logic neg);
    if (pos) return DIG_POS;
    if (neg) return DIG_NEG;
    return DIG_ZERO;
  endfunction

  function automatic int digit_shift(input int k, input int cf);
    return k - cf;
  endfunction
endpackage

// File: rtl/csd_digit_term.sv
module csd_digit_term #(
  parameter int AW    = 28,
  parameter int SHIFT = 0,
  parameter bit NEG   = 1'b0
) (
  input  logic [AW-1:0] xg_i,
  output logic [AW-1:0] term_o
);
  logic [AW-1:0] shifted;

  generate
    if (SHIFT >= 0) begin : g_left
      assign shifted = xg_i << SHIFT;
    end else begin : g_right
      localparam int RSH = -SHIFT;
      assign shifted = AW'($signed(xg_i) >>> RSH);
    end
    if (NEG) begin : g_sub
      assign term_o = AW'(0) - shifted;
    end else begin : g_add
      assign term_o = shifted;
    end
  endgenerate
endmodule

// File: rtl/csd_accum.sv
module csd_accum #(
  parameter int AW = 28,
  parameter int N  = 22
) (
  input  logic [N-1:0][AW-1:0] terms_i,
  output logic [AW-1:0]        sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + terms_i[i];
  end
endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage #(
  parameter int DW      = 25,
  parameter int GUARD   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW+GUARD-1:0] sum_i,
  output logic [DW-1:0]       y_o
);
  logic [DW-1:0]    y_trunc;
  logic [DW-1:0]    y_q;
  logic [GUARD-1:0] unused_guard;

  // drop guard LSBs: floor toward -inf
  assign y_trunc      = sum_i[DW+GUARD-1:GUARD];
  assign unused_guard = sum_i[GUARD-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_trunc;
  end

  assign y_o = OUT_REG ? y_q : y_trunc;
endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csd_mult_pkg::*;
#(
  parameter int             DW       = 25,
  parameter int             FW       = 14,
  parameter int             GUARD    = 3,
  parameter int             CD       = 22,
  parameter int             CF       = 14,
  parameter logic [CD-1:0]  POS_MASK = 22'h004100,
  parameter logic [CD-1:0]  NEG_MASK = 22'h000410,
  parameter bit             OUT_REG  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] y_o
);
  localparam int            AW       = DW + GUARD;
  localparam logic [CD-1:0] NZ_MASK  = POS_MASK | NEG_MASK;
  localparam int            FW_CHECK = FW;

  logic [AW-1:0]         xg;
  logic [CD-1:0][AW-1:0] terms;
  logic [AW-1:0]         sum;

  generate
    if ((POS_MASK & NEG_MASK) != '0) begin : g_bad_overlap
      $error("digit set in both masks");
    end
    if ((NZ_MASK & (NZ_MASK >> 1)) != '0) begin : g_bad_adjacent
      $error("adjacent non-zero digits");
    end
    if (FW_CHECK >= DW) begin : g_bad_fw
      $error("fraction width exceeds word width");
    end
  endgenerate

  assign xg = {x_i, {GUARD{1'b0}}};

  for (genvar k = 0; k < CD; k++) begin : g_digit
    localparam digit_e DIG = digit_at(POS_MASK[k], NEG_MASK[k]);
    if (DIG == DIG_ZERO) begin : g_none
      assign terms[k] = '0;
    end else begin : g_term
      csd_digit_term #(
        .AW   (AW),
        .SHIFT(digit_shift(k, CF)),
        .NEG  (DIG == DIG_NEG)
      ) term_i (
        .xg_i  (xg),
        .term_o(terms[k])
      );
    end
  end

  csd_accum #(.AW(AW), .N(CD)) accum_i (
    .terms_i(terms),
    .sum_o  (sum)
  );

  csd_out_stage #(.DW(DW), .GUARD(GUARD), .OUT_REG(OUT_REG)) out_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sum_i (sum),
    .y_o   (y_o)
  );
endmodule

// File: rtl/csd_const_mult_chk.sv
module csd_const_mult_chk #(
  parameter int            DW       = 25,
  parameter int            CD       = 22,
  parameter logic [CD-1:0] POS_MASK = '0,
  parameter logic [CD-1:0] NEG_MASK = '0,
  parameter bit            OUT_REG  = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] x_i,
  input logic [DW-1:0] y_o
);
  localparam bit ZERO_COEF = ((POS_MASK | NEG_MASK) == '0);

  logic [1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (run_q != 2'd2) run_q <= run_q + 2'd1;
  end

  AST_ZERO_COEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ZERO_COEF |-> y_o == '0); // R6
  AST_ZERO_IN_COMB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!OUT_REG && x_i == '0) |-> y_o == '0); // R7
  AST_ZERO_IN_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && run_q != 2'd0 && $past(x_i) == '0) |-> y_o == '0); // R7
  AST_COMB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!OUT_REG && $stable(x_i)) |-> $stable(y_o)); // R8
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && run_q == 2'd2 && $past(x_i) == $past(x_i, 2)) |-> $stable(y_o)); // R8
endmodule

bind csd_const_mult csd_const_mult_chk #(
  .DW(DW), .CD(CD), .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK), .OUT_REG(OUT_REG)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .y_o(y_o)
);

// File: tb/csd_const_mult_tb_top.sv
module csd_const_mult_tb_top;
  localparam int DW = 8, FW = 4, G = 3, CD = 8, CF = 4;
  localparam logic [7:0] A_POS = 8'h11, A_NEG = 8'h04;  // +1 +1/16 -1/4
  localparam logic [7:0] B_POS = 8'h05, B_NEG = 8'h50;  // 1/16+1/4-1-4
  localparam logic [7:0] W_POS = 8'h80, W_NEG = 8'h00;  // x8

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] x = '0;
  logic [7:0] y_reg, y_comb, y_mix, y_wrap, y_zero;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csd_const_mult #(.DW(DW), .FW(FW), .GUARD(G), .CD(CD), .CF(CF),
    .POS_MASK(A_POS), .NEG_MASK(A_NEG), .OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_reg));
  csd_const_mult #(.DW(DW), .FW(FW), .GUARD(G), .CD(CD), .CF(CF),
    .POS_MASK(A_POS), .NEG_MASK(A_NEG), .OUT_REG(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_comb));
  csd_const_mult #(.DW(DW), .FW(FW), .GUARD(G), .CD(CD), .CF(CF),
    .POS_MASK(B_POS), .NEG_MASK(B_NEG), .OUT_REG(1'b0)) dut_mix_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_mix));
  csd_const_mult #(.DW(DW), .FW(FW), .GUARD(G), .CD(CD), .CF(CF),
    .POS_MASK(W_POS), .NEG_MASK(W_NEG), .OUT_REG(1'b0)) dut_wrap_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_wrap));
  csd_const_mult #(.DW(DW), .FW(FW), .GUARD(G), .CD(CD), .CF(CF),
    .POS_MASK(8'h00), .NEG_MASK(8'h00), .OUT_REG(1'b0)) dut_zero_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_o(y_zero));

  // integer model: guard-extended terms, one floor at the end, modulo 2^DW
  function automatic logic [7:0] model(input logic [7:0] xv, input logic [7:0] pm,
                                       input logic [7:0] nm);
    longint xg;
    longint acc;
    xg  = longint'($signed(xv)) * (longint'(1) << G);
    acc = 0;
    for (int k = 0; k < CD; k++) begin
      longint p;
      int s;
      s = k - CF;
      p = (s >= 0) ? (xg <<< s) : (xg >>> (-s));
      if (pm[k]) acc = acc + p;
      if (nm[k]) acc = acc - p;
    end
    acc = acc >>> G;
    return acc[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s x=%h act=%h exp=%h", req, x, act, exp);
    end
  endtask

  initial begin
    logic [7:0] prev;
    #1;
    check("R8 reset value", y_reg, 8'h00);
    @(negedge clk);
    check("R8 reset held", y_reg, 8'h00);
    rst_n = 1'b1;
    prev = 8'h00;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      x = 8'(i);
      #1;
      check("R8 register not yet updated", y_reg, model(prev, A_POS, A_NEG));
      check("R1 R2 R4 mixed fractional constant", y_comb, model(x, A_POS, A_NEG));
      check("R3 R5 negative constant with wrap", y_mix, model(x, B_POS, B_NEG));
      check("R5 wrap vs integer product", y_wrap, 8'(int'($signed(x)) * 8));
      check("R6 zero constant", y_zero, 8'h00);
      if (i == 0) begin
        check("R7 zero input mixed", y_mix, 8'h00);
        check("R7 zero input wrap", y_wrap, 8'h00);
      end
      @(posedge clk);
      #1;
      check("R8 registered output after edge", y_reg, model(x, A_POS, A_NEG));
      prev = x;
    end
    // R4: 1/16 * 0.8125 floors to 0; 0.5 * -4.6875 = -2.34375 floors to -2.375 (0xDA)
    @(negedge clk); x = 8'h01; #1;
    check("R4 floor small product", y_comb, 8'h00);
    @(negedge clk); x = 8'h08; #1;
    check("R4 floor negative product", y_mix, 8'hDA);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule